// File: doc/BRIEF.md
# Dual-Address Packet Address Filter

This block sits between a media-access engine and a set of local service processors that share one packet path. Packets arrive as 16-bit words, with a start marker on the first word and an end marker on the last. The first word carries the destination: a type bit, an 11-bit identifier and a 4-bit sub-address. The filter compares the type and identifier against one of two programmed identifiers. A node-type address is checked against the node register. A group-type address is checked against the group register, which gives multicast delivery.

An accepted packet is passed on without its address word, one cycle after each word enters. Each output word carries the sub-address of the packet, which picks the target processor. The first information word is also flagged with a one-cycle ready pulse, and a 4-bit control code is taken from the top nibble of that word and held for the rest of the packet. A rejected packet produces no output at all until the next start marker.

The two identifiers are written through a small configuration port. A write made while reset is applied, or while no packet is open, takes effect at once. A write made during a packet is held back and applied on the first idle cycle after that packet has ended.

Top module: `pkt_addr_filter`

## Requirements
- R1: While reset is held and after it is released, out_valid and out_ready are 0 and out_word is 0 until a packet is accepted.
- R2: An address word (in_valid=1, in_sop=1) with bit 15 = 1 and bits 14:4 equal to the node register is accepted. Each later valid word of that packet appears on out_word with out_valid=1 exactly one clock later. Cycles with in_valid=0 produce no output.
- R3: An address word with bit 15 = 0 and bits 14:4 equal to the group register is accepted and forwarded in the same way.
- R4: The type bit selects the register used for the comparison. A node-type address whose identifier matches only the group register is rejected, and so is a group-type address whose identifier matches only the node register.
- R5: The sub-address (address bits 3:0) is never compared. It appears on out_sub with every forwarded word of the packet.
- R6: out_ready is high for one cycle only, together with the first forwarded information word. out_ctrl takes bits 15:12 of that word and holds that value for the rest of the packet.
- R7: After a rejected address word, or after the word carrying in_eop, valid words that have no in_sop produce neither out_valid nor out_ready.
- R8: A new in_sop word ends any open packet, accepted or rejected, and the filter evaluates it as a fresh address.
- R9: A configuration write (cfg_sel 0 = node, 1 = group) made while a packet is open takes effect only on the first cycle that has no open packet and no start marker. A write made in such an idle cycle applies to the very next address word.
- R10: Configuration writes made while reset is held load the registers directly.
- R11: The address word itself is never forwarded, and a packet made of a single word (in_sop together with in_eop) produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is valid |
| in_sop | input | 1 | Word is the address word of a new packet |
| in_eop | input | 1 | Word is the last word of its packet |
| in_word | input | 16 | Packet word from the access engine |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register to write: 0 node, 1 group |
| cfg_id | input | 11 | Identifier value to write |
| out_valid | output | 1 | Forwarded word is valid |
| out_ready | output | 1 | Marks the first information word of an accepted packet |
| out_word | output | 16 | Forwarded information word |
| out_sub | output | 4 | Sub-address of the current packet |
| out_ctrl | output | 4 | Control code parsed from the first information word |

## Verification
The bench builds the filter with its default widths: 16-bit words, an 11-bit identifier, a 4-bit sub-address and the control code taken from the top nibble. At these values the node and group identifiers can be chosen so that one identifier field matches only the opposite register, which makes the test of the type bit's register choice possible. Several sub-address values, including all-ones, can be sent across packets. With a 16-bit word the control nibble and the forwarded word can be checked against each other field by field. These values also allow the tests of a deferred write under a restarted packet and of an immediate write while idle.

// File: rtl/pkt_filt_pkg.sv
package pkt_filt_pkg;
   typedef enum logic {
      CFG_NODE  = 1'b0,
      CFG_GROUP = 1'b1
   } cfg_sel_e;

   localparam logic ADDR_IS_GROUP = 1'b0;
   localparam logic ADDR_IS_NODE  = 1'b1;
endpackage

// File: rtl/pkt_filt_match.sv
module pkt_filt_match #(
   parameter int ID_W   = 11,
   parameter int SUB_W  = 4,
   parameter int WORD_W = 1 + ID_W + SUB_W
) (
   input  logic [WORD_W-1:0] addr_word,
   input  logic [ID_W-1:0]   node_id,
   input  logic [ID_W-1:0]   group_id,
   output logic              hit,
   output logic [SUB_W-1:0]  sub
);
   import pkt_filt_pkg::*;

   localparam int TYPE_BIT = WORD_W - 1;
   localparam int ID_LO    = SUB_W;

   logic              addr_type;
   logic [ID_W-1:0]   addr_id;
   logic [ID_W-1:0]   ref_id;

   assign addr_type = addr_word[TYPE_BIT];
   assign addr_id   = addr_word[ID_LO +: ID_W];
   assign sub       = addr_word[SUB_W-1:0];

   always_comb begin
      ref_id = (addr_type == ADDR_IS_NODE) ? node_id : group_id;
      hit    = (addr_id == ref_id);
   end
endmodule

// File: rtl/pkt_filt_cfg.sv
module pkt_filt_cfg #(
   parameter int ID_W = 11
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 idle,
   input  logic                 cfg_we,
   input  logic                 cfg_sel,
   input  logic [ID_W-1:0]      cfg_id,
   output logic [1:0][ID_W-1:0] ids
);
   localparam int NREG = 2;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [ID_W-1:0] act_q;
      logic [ID_W-1:0] shadow_q;
      logic            pend_q;
      logic            wr;

      assign wr = cfg_we && (cfg_sel == i[0]);

      always_ff @(posedge clk) begin
         if (wr && idle) begin
            act_q <= cfg_id;
         end else if (wr) begin
            shadow_q <= cfg_id;
         end else if (pend_q && idle) begin
            act_q <= shadow_q;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
         end else if (wr) begin
            pend_q <= !idle;
         end else if (idle) begin
            pend_q <= 1'b0;
         end
      end

      assign ids[i] = act_q;
   end
endmodule

// File: rtl/pkt_filt_track.sv
module pkt_filt_track #(
   parameter int WORD_W         = 16,
   parameter int SUB_W          = 4,
   parameter int CTRL_W         = 4,
   parameter bit CTRL_FROM_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [WORD_W-1:0] in_word,
   input  logic              hit,
   input  logic [SUB_W-1:0]  sub_in,
   output logic              open_o,
   output logic              out_valid,
   output logic              out_ready,
   output logic [WORD_W-1:0] out_word,
   output logic [SUB_W-1:0]  out_sub,
   output logic [CTRL_W-1:0] out_ctrl
);
   logic              open_q;
   logic              acc_q;
   logic              first_q;
   logic [SUB_W-1:0]  sub_q;
   logic [CTRL_W-1:0] ctrl_field;

   if (CTRL_FROM_HIGH) begin : g_ctrl_hi
      assign ctrl_field = in_word[WORD_W-1 -: CTRL_W];
   end else begin : g_ctrl_lo
      assign ctrl_field = in_word[CTRL_W-1:0];
   end

   assign open_o = open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q    <= 1'b0;
         acc_q     <= 1'b0;
         first_q   <= 1'b0;
         sub_q     <= '0;
         out_valid <= 1'b0;
         out_ready <= 1'b0;
         out_word  <= '0;
         out_sub   <= '0;
         out_ctrl  <= '0;
      end else begin
         out_valid <= 1'b0;
         out_ready <= 1'b0;
         if (in_valid) begin
            if (in_sop) begin
               open_q  <= !in_eop;
               acc_q   <= hit;
               first_q <= 1'b1;
               sub_q   <= sub_in;
            end else if (open_q) begin
               if (acc_q) begin
                  out_valid <= 1'b1;
                  out_ready <= first_q;
                  out_word  <= in_word;
                  out_sub   <= sub_q;
                  if (first_q) begin
                     out_ctrl <= ctrl_field;
                  end
               end
               first_q <= 1'b0;
               if (in_eop) begin
                  open_q <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/pkt_addr_filter.sv
module pkt_addr_filter #(
   parameter int ID_W           = 11,
   parameter int SUB_W          = 4,
   parameter int CTRL_W         = 4,
   parameter bit CTRL_FROM_HIGH = 1'b1,
   parameter int WORD_W         = 1 + ID_W + SUB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [WORD_W-1:0] in_word,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [ID_W-1:0]   cfg_id,
   output logic              out_valid,
   output logic              out_ready,
   output logic [WORD_W-1:0] out_word,
   output logic [SUB_W-1:0]  out_sub,
   output logic [CTRL_W-1:0] out_ctrl
);
   import pkt_filt_pkg::*;

   if (WORD_W != 1 + ID_W + SUB_W) begin : g_bad_word
      $error("word width must equal type bit plus identifier plus sub-address");
   end
   if (CTRL_W < 1 || CTRL_W > WORD_W) begin : g_bad_ctrl
      $error("control field must fit inside one word");
   end
   if (ID_W < 1 || SUB_W < 1) begin : g_bad_fields
      $error("identifier and sub-address need at least one bit");
   end

   logic [1:0][ID_W-1:0] ids;
   logic [ID_W-1:0]      node_id;
   logic [ID_W-1:0]      group_id;
   logic                 hit;
   logic [SUB_W-1:0]     sub;
   logic                 pkt_open;
   logic                 idle;

   assign node_id  = ids[CFG_NODE];
   assign group_id = ids[CFG_GROUP];
   assign idle     = !rst_n || (!pkt_open && !(in_valid && in_sop));

   pkt_filt_cfg #(.ID_W(ID_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .idle    (idle),
      .cfg_we  (cfg_we),
      .cfg_sel (cfg_sel),
      .cfg_id  (cfg_id),
      .ids     (ids)
   );

   pkt_filt_match #(.ID_W(ID_W), .SUB_W(SUB_W), .WORD_W(WORD_W)) u_match (
      .addr_word (in_word),
      .node_id   (node_id),
      .group_id  (group_id),
      .hit       (hit),
      .sub       (sub)
   );

   pkt_filt_track #(
      .WORD_W(WORD_W), .SUB_W(SUB_W), .CTRL_W(CTRL_W), .CTRL_FROM_HIGH(CTRL_FROM_HIGH)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sop    (in_sop),
      .in_eop    (in_eop),
      .in_word   (in_word),
      .hit       (hit),
      .sub_in    (sub),
      .open_o    (pkt_open),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_word  (out_word),
      .out_sub   (out_sub),
      .out_ctrl  (out_ctrl)
   );
endmodule

// File: rtl/pkt_addr_filter_chk.sv
module pkt_addr_filter_chk #(
   parameter int ID_W   = 11,
   parameter int SUB_W  = 4,
   parameter int CTRL_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_sop,
   input logic              out_valid,
   input logic              out_ready,
   input logic [SUB_W-1:0]  out_sub,
   input logic [CTRL_W-1:0] out_ctrl,
   input logic              pkt_open,
   input logic [ID_W-1:0]   node_id,
   input logic [ID_W-1:0]   group_id
);
   AST_READY_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> out_valid); // R6
   AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |=> !out_ready); // R6
   AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid)); // R2
   AST_ADDR_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && in_sop) |-> !out_valid); // R11
   AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> ($stable(out_sub) && $stable(out_ctrl))); // R5
   AST_CFG_HELD_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pkt_open || (in_valid && in_sop)) |-> ($stable(node_id) && $stable(group_id))); // R9
endmodule

bind pkt_addr_filter pkt_addr_filter_chk #(.ID_W(ID_W), .SUB_W(SUB_W), .CTRL_W(CTRL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_sop    (in_sop),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_sub   (out_sub),
   .out_ctrl  (out_ctrl),
   .pkt_open  (pkt_open),
   .node_id   (node_id),
   .group_id  (group_id)
);

// File: tb/sim_pkt_addr_filter.sv
module sim_pkt_addr_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [15:0] in_word = '0;
   logic        cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [10:0] cfg_id = '0;
   logic        out_valid, out_ready;
   logic [15:0] out_word;
   logic [3:0]  out_sub, out_ctrl;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   pkt_addr_filter u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
      .in_word(in_word), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_id(cfg_id),
      .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
      .out_sub(out_sub), .out_ctrl(out_ctrl)
   );

   typedef struct packed {
      logic        v;
      logic        s;
      logic        e;
      logic [15:0] w;
      logic        ev;
      logic        er;
      logic [3:0]  es;
      logic [3:0]  ec;
      logic [7:0]  req;
   } vec_t;

   // node id 0x2A5, group id 0x133, both loaded during reset
   localparam int NV = 21;
   localparam vec_t TBL [NV] = '{
      '{1'b1,1'b1,1'b0,16'hAA57,1'b0,1'b0,4'h0,4'h0,8'd11}, // R11 node address word
      '{1'b1,1'b0,1'b0,16'hC123,1'b1,1'b1,4'h7,4'hC,8'd2},  // R2 R6 R10 first info word
      '{1'b1,1'b0,1'b0,16'h4567,1'b1,1'b0,4'h7,4'hC,8'd5},  // R5 continuation
      '{1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,4'h0,4'h0,8'd2},  // R2 gap
      '{1'b1,1'b0,1'b1,16'h89AB,1'b1,1'b0,4'h7,4'hC,8'd6},  // R6 last word
      '{1'b1,1'b0,1'b0,16'h1111,1'b0,1'b0,4'h0,4'h0,8'd7},  // R7 after eop
      '{1'b1,1'b1,1'b0,16'h1333,1'b0,1'b0,4'h0,4'h0,8'd3},  // R3 group address
      '{1'b1,1'b0,1'b1,16'h5000,1'b1,1'b1,4'h3,4'h5,8'd3},  // R3 forwarded
      '{1'b1,1'b1,1'b0,16'h9331,1'b0,1'b0,4'h0,4'h0,8'd4},  // R4 node type, group id
      '{1'b1,1'b0,1'b0,16'h6000,1'b0,1'b0,4'h0,4'h0,8'd4},
      '{1'b1,1'b0,1'b1,16'h7000,1'b0,1'b0,4'h0,4'h0,8'd4},
      '{1'b1,1'b1,1'b0,16'h2A52,1'b0,1'b0,4'h0,4'h0,8'd4},  // R4 group type, node id
      '{1'b1,1'b0,1'b1,16'h8888,1'b0,1'b0,4'h0,4'h0,8'd4},
      '{1'b1,1'b1,1'b0,16'hAA45,1'b0,1'b0,4'h0,4'h0,8'd7},  // R7 wrong node id
      '{1'b1,1'b0,1'b0,16'h9999,1'b0,1'b0,4'h0,4'h0,8'd7},
      '{1'b1,1'b1,1'b0,16'hAA5F,1'b0,1'b0,4'h0,4'h0,8'd8},  // R8 restart over rejected
      '{1'b1,1'b0,1'b0,16'hE001,1'b1,1'b1,4'hF,4'hE,8'd8},  // R8 R5 sub all ones
      '{1'b1,1'b1,1'b0,16'h133C,1'b0,1'b0,4'h0,4'h0,8'd8},  // R8 restart over accepted
      '{1'b1,1'b0,1'b1,16'h2222,1'b1,1'b1,4'hC,4'h2,8'd8},
      '{1'b1,1'b1,1'b1,16'hAA57,1'b0,1'b0,4'h0,4'h0,8'd11}, // R11 single-word packet
      '{1'b1,1'b0,1'b0,16'h3333,1'b0,1'b0,4'h0,4'h0,8'd11}
   };

   task automatic chk(input bit ok, input int req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic v, s, e, input logic [15:0] w,
                       input logic ev, er, input logic [3:0] es, ec, input int req);
      @(negedge clk);
      in_valid = v; in_sop = s; in_eop = e; in_word = w;
      @(posedge clk);
      #1;
      chk(out_valid == ev, req, "out_valid", {15'd0, out_valid}, {15'd0, ev});
      chk(out_ready == er, req, "out_ready", {15'd0, out_ready}, {15'd0, er});
      if (ev) begin
         chk(out_word == w, req, "out_word", out_word, w);
         chk(out_sub == es, req, "out_sub", {12'd0, out_sub}, {12'd0, es});
         chk(out_ctrl == ec, req, "out_ctrl", {12'd0, out_ctrl}, {12'd0, ec});
      end
   endtask

   task automatic cfg_write(input logic sel, input logic [10:0] id);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      cfg_we = 1'b1; cfg_sel = sel; cfg_id = id;
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
   endtask

   initial begin
      // R10: load both registers while reset is held
      cfg_write(1'b0, 11'h2A5);
      cfg_write(1'b1, 11'h133);
      @(negedge clk);
      // R1: reset state
      chk(out_valid == 1'b0, 1, "out_valid in reset", {15'd0, out_valid}, 16'd0);
      chk(out_ready == 1'b0, 1, "out_ready in reset", {15'd0, out_ready}, 16'd0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(out_valid == 1'b0, 1, "out_valid after reset", {15'd0, out_valid}, 16'd0);
      chk(out_word == 16'h0, 1, "out_word after reset", out_word, 16'h0);

      for (int i = 0; i < NV; i++) begin
         step(TBL[i].v, TBL[i].s, TBL[i].e, TBL[i].w, TBL[i].ev, TBL[i].er,
              TBL[i].es, TBL[i].ec, int'(TBL[i].req));
      end

      // R9: write during an open packet is held back
      step(1'b1, 1'b1, 1'b0, 16'hAA57, 1'b0, 1'b0, 4'h0, 4'h0, 9);
      step(1'b1, 1'b0, 1'b0, 16'h1000, 1'b1, 1'b1, 4'h7, 4'h1, 9);
      cfg_write(1'b0, 11'h155);
      step(1'b1, 1'b1, 1'b0, 16'hAA57, 1'b0, 1'b0, 4'h0, 4'h0, 9);
      step(1'b1, 1'b0, 1'b0, 16'h2000, 1'b1, 1'b1, 4'h7, 4'h2, 9); // old id still used
      step(1'b1, 1'b0, 1'b1, 16'h3000, 1'b1, 1'b0, 4'h7, 4'h2, 9);
      step(1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'h0, 4'h0, 9); // idle: write applies
      step(1'b1, 1'b1, 1'b0, 16'hAA57, 1'b0, 1'b0, 4'h0, 4'h0, 9);
      step(1'b1, 1'b0, 1'b1, 16'h4000, 1'b0, 1'b0, 4'h0, 4'h0, 9); // old id now rejected
      step(1'b1, 1'b1, 1'b0, 16'h9552, 1'b0, 1'b0, 4'h0, 4'h0, 9);
      step(1'b1, 1'b0, 1'b1, 16'h5000, 1'b1, 1'b1, 4'h2, 4'h5, 9); // new id accepted

      // R9: write while idle applies to the next address word
      cfg_write(1'b1, 11'h0AA);
      step(1'b1, 1'b1, 1'b0, 16'h0AA1, 1'b0, 1'b0, 4'h0, 4'h0, 9);
      step(1'b1, 1'b0, 1'b1, 16'h6000, 1'b1, 1'b1, 4'h1, 4'h6, 9);
      step(1'b1, 1'b1, 1'b0, 16'h1333, 1'b0, 1'b0, 4'h0, 4'h0, 9);
      step(1'b1, 1'b0, 1'b1, 16'h7000, 1'b0, 1'b0, 4'h0, 4'h0, 9); // old group rejected
      step(1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'h0, 4'h0, 2);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL R1 watchdog: actual hung expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule